// File: doc/BRIEF.md
# Paged Interrupt Status Controller

This block is the byte-wide host register front end that collects interrupt causes for a network controller. A command register, present at offset zero on every page, carries a two-bit page selector in its top bits. That selector decides which register an address reaches. On page 0, the block exposes an eight-bit interrupt status register and an interrupt mask register. On page 1, the status offset reaches a current-page register instead.

The packet datapaths report events as single-cycle pulses, one per cause. Each pulse sets its status bit, and the bit stays set until the host writes a one to that position. A level interrupt output is high while any status bit is set and enabled by its mask bit. A read of the reset port on page 0 returns zero and flags the reset-complete cause, so software can trigger that cause itself.

Top module: `pisc_top`

## Requirements
- R1: After reset, the command register reads 0x01, the status register reads 0x00, irq is low, and the current-page register reads 0x4C (parameter CURPG_RST).
- R2: A write to offset 0x00 on any page loads the command register, except that bit 2 stays one once it is one. Bits 7:6 of the command register select the page (00 = page 0, 01 = page 1).
- R3: An event pulse on evt_i[n] sets status bit n, and a read of offset 0x07 on page 0 returns the status byte. The bit meanings are: 0 receive good, 1 transmit good, 2 receive error, 3 transmit error, 4 ring overwrite, 5 counters need service, 6 remote transfer complete, 7 reset complete.
- R4: A write to offset 0x07 on page 0 clears each status bit whose written bit is one and leaves the other status bits unchanged.
- R5: When an event and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R6: A write to offset 0x0F on page 0 loads the mask. irq is high exactly while (status AND mask) is nonzero.
- R7: Clearing an enabled status bit, or clearing its mask bit, drops irq in the cycle after the write.
- R8: A read of offset 0x1F on page 0 returns 0x00 and sets status bit 7.
- R9: On page 1, offset 0x07 reads and writes the current-page register, and such a write leaves the status register unchanged.
- R10: On any page other than 0, writes to offsets 0x07 and 0x0F and reads of 0x1F leave the status and mask unchanged. On pages 2 and 3, offset 0x07 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 5 | Register offset |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of the read strobe |
| evt_i | input | 8 | Event pulses, one per status bit |
| irq_o | output | 1 | Level interrupt request |

## Verification
Each storage element here can be observed at a port. A status flop that is stuck, or that misses the set-over-clear rule, shows up on the first page-0 read of offset 0x07. A mask fault shows up on irq in the same cycle that the status byte changes. A page-decode fault makes one register corrupt another. The bench reveals this by writing through page 1, page 2 or page 3 and then reading back both the status and the irq level on page 0. A command-register fault that loses bit 2, or that puts the page field in the wrong bits, shows up in the very next read of offset 0x00, or as a misrouted access right after it.

// File: rtl/pisc_pkg.sv
package pisc_pkg;
   localparam int unsigned OFF_CMD  = 0;
   localparam int unsigned OFF_ISR  = 7;
   localparam int unsigned OFF_MASK = 15;
   localparam int unsigned OFF_RPRT = 31;
   localparam int unsigned BIT_RST  = 7;

   typedef enum logic [1:0] {
      PG_ZERO  = 2'd0,
      PG_ONE   = 2'd1,
      PG_TWO   = 2'd2,
      PG_THREE = 2'd3
   } page_e;

   typedef struct packed {
      logic cmd_wr;
      logic isr_wr;
      logic isr_rd;
      logic mask_wr;
      logic cpg_wr;
      logic cpg_rd;
      logic rprt_rd;
      logic cmd_rd;
   } dec_t;
endpackage

// File: rtl/pisc_page_decode.sv
module pisc_page_decode
   import pisc_pkg::*;
#(
   parameter int unsigned ADDR_W = 5
) (
   input  page_e              page_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               wr_i,
   input  logic               rd_i,
   output dec_t               dec_o
);
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
   localparam logic [ADDR_W-1:0] A_ISR  = ADDR_W'(OFF_ISR);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
   localparam logic [ADDR_W-1:0] A_RPRT = ADDR_W'(OFF_RPRT);

   logic on_p0, on_p1;
   assign on_p0 = (page_i == PG_ZERO);
   assign on_p1 = (page_i == PG_ONE);

   always_comb begin
      dec_o         = '0;
      dec_o.cmd_wr  = wr_i && (addr_i == A_CMD);
      dec_o.cmd_rd  = rd_i && (addr_i == A_CMD);
      dec_o.isr_wr  = wr_i && on_p0 && (addr_i == A_ISR);
      dec_o.isr_rd  = rd_i && on_p0 && (addr_i == A_ISR);
      dec_o.mask_wr = wr_i && on_p0 && (addr_i == A_MASK);
      dec_o.rprt_rd = rd_i && on_p0 && (addr_i == A_RPRT);
      dec_o.cpg_wr  = wr_i && on_p1 && (addr_i == A_ISR);
      dec_o.cpg_rd  = rd_i && on_p1 && (addr_i == A_ISR);
   end
endmodule

// File: rtl/pisc_status_reg.sv
module pisc_status_reg #(
   parameter int unsigned NBITS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] set_i,
   input  logic             clr_en_i,
   input  logic [NBITS-1:0] clr_mask_i,
   output logic [NBITS-1:0] q_o
);
   for (genvar b = 0; b < NBITS; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)                          q_o[b] <= 1'b0;
         else if (set_i[b])                   q_o[b] <= 1'b1;
         else if (clr_en_i && clr_mask_i[b])  q_o[b] <= 1'b0;
      end
   end
endmodule

// File: rtl/pisc_irq_gen.sv
module pisc_irq_gen #(
   parameter int unsigned NBITS      = 8,
   parameter bit          REGISTERED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] status_i,
   input  logic [NBITS-1:0] mask_i,
   output logic             irq_o
);
   logic pend;
   assign pend = |(status_i & mask_i);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= pend;
      end
   end else begin : g_comb
      assign irq_o = pend;
   end
endmodule

// File: rtl/pisc_top.sv
module pisc_top
   import pisc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned DATA_W     = 8,
   parameter logic [7:0]  CMD_RST    = 8'h01,
   parameter logic [7:0]  CURPG_RST  = 8'h4C,
   parameter bit          IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [DATA_W-1:0] evt_i,
   output logic              irq_o
);
   localparam int unsigned PG_HI  = DATA_W - 1;
   localparam int unsigned PG_LO  = DATA_W - 2;
   localparam int unsigned TX_BIT = 2;

   if (DATA_W != 8) begin : g_bad_width
      $error("pisc_top: DATA_W must be 8");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("pisc_top: ADDR_W must reach offset 0x1F");
   end

   logic [DATA_W-1:0] cmd_q, mask_q, cpg_q, status_q, evt_all;
   page_e             page;
   dec_t              dec;

   assign page = page_e'(cmd_q[PG_HI:PG_LO]);

   pisc_page_decode #(.ADDR_W(ADDR_W)) u_dec (
      .page_i (page),
      .addr_i (addr_i),
      .wr_i   (wr_i),
      .rd_i   (rd_i),
      .dec_o  (dec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= CMD_RST;
         mask_q <= '0;
         cpg_q  <= CURPG_RST;
      end else begin
         if (dec.cmd_wr) begin
            cmd_q         <= wdata_i;
            cmd_q[TX_BIT] <= wdata_i[TX_BIT] | cmd_q[TX_BIT];
         end
         if (dec.mask_wr) mask_q <= wdata_i;
         if (dec.cpg_wr)  cpg_q  <= wdata_i;
      end
   end

   always_comb begin
      evt_all          = evt_i;
      evt_all[BIT_RST] = evt_i[BIT_RST] | dec.rprt_rd;
   end

   pisc_status_reg #(.NBITS(DATA_W)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (evt_all),
      .clr_en_i   (dec.isr_wr),
      .clr_mask_i (wdata_i),
      .q_o        (status_q)
   );

   pisc_irq_gen #(.NBITS(DATA_W), .REGISTERED(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status_q),
      .mask_i   (mask_q),
      .irq_o    (irq_o)
   );

   always_comb begin
      rdata_o = '0;
      if (dec.cmd_rd)      rdata_o = cmd_q;
      else if (dec.isr_rd) rdata_o = status_q;
      else if (dec.cpg_rd) rdata_o = cpg_q;
   end
endmodule

// File: rtl/pisc_checker.sv
module pisc_checker #(
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr,
   input logic              rd,
   input logic [7:0]        wdata,
   input logic [7:0]        rdata,
   input logic [7:0]        evt,
   input logic [7:0]        cmd,
   input logic [7:0]        status,
   input logic [7:0]        mask,
   input logic              irq
);
   logic on_p0;
   assign on_p0 = (cmd[7:6] == 2'b00);

   AST_TXBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd[2] |=> cmd[2]); // R2

   AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & ~$past(status) & ~$past(evt)) & 8'h7F) == 8'h00); // R3

   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != 8'h00) |=> ((status & $past(evt)) == $past(evt))); // R5

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && on_p0 && addr == ADDR_W'(7) && rd == 1'b0 && evt == 8'h00)
      |=> ((status & $past(wdata)) == 8'h00)); // R4

   AST_RPRT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && on_p0 && addr == ADDR_W'(31)) |-> (rdata == 8'h00)); // R8

   AST_RPRT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && on_p0 && addr == ADDR_W'(31)) |=> status[7]); // R8

   AST_IRQ_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((status | $past(status)) != 8'h00)); // R6

   AST_MASK_OFFPAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!on_p0) |=> $stable(mask)); // R10
endmodule

bind pisc_top pisc_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .addr   (addr_i),
   .wr     (wr_i),
   .rd     (rd_i),
   .wdata  (wdata_i),
   .rdata  (rdata_o),
   .evt    (evt_i),
   .cmd    (cmd_q),
   .status (status_q),
   .mask   (mask_q),
   .irq    (irq_o)
);

// File: tb/pisc_top_tb.sv
module pisc_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] addr = '0;
   logic       wr = 1'b0, rd = 1'b0;
   logic [7:0] wdata = '0, evt = '0;
   logic [7:0] rdata;
   logic       irq;
   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   pisc_top dut_i (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
      .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [4:0] a, input logic [7:0] d, input logic [7:0] e = 8'h00);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1; evt = e;
      @(negedge clk);
      wr = 1'b0; evt = '0;
   endtask

   task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic pulse(input logic [7:0] e);
      @(negedge clk);
      evt = e;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd_reg(5'h00, v); check("R1 cmd", v, 8'h01);
      rd_reg(5'h07, v); check("R1 status", v, 8'h00);
      check("R1 irq", {7'd0, irq}, 8'h00);
      wr_reg(5'h00, 8'h40);
      rd_reg(5'h07, v); check("R1 curpg", v, 8'h4C);
      wr_reg(5'h00, 8'h00);
   endtask

   task automatic t_events();
      logic [7:0] v;
      pulse(8'h01);
      rd_reg(5'h07, v); check("R3 bit0", v, 8'h01);
      pulse(8'h50);
      rd_reg(5'h07, v); check("R3 bits4,6", v, 8'h51);
      pulse(8'h80);
      rd_reg(5'h07, v); check("R3 bit7", v, 8'hD1);
   endtask

   task automatic t_w1c();
      logic [7:0] v;
      wr_reg(5'h07, 8'h11);
      rd_reg(5'h07, v); check("R4 partial clear", v, 8'hC0);
      wr_reg(5'h07, 8'hFF);
      rd_reg(5'h07, v); check("R4 full clear", v, 8'h00);
   endtask

   task automatic t_setwins();
      logic [7:0] v;
      pulse(8'h02);
      wr_reg(5'h07, 8'h03, 8'h02);
      rd_reg(5'h07, v); check("R5 set beats clear", v, 8'h02);
      wr_reg(5'h07, 8'h02, 8'h08);
      rd_reg(5'h07, v); check("R5 other bit", v, 8'h08);
      wr_reg(5'h07, 8'hFF);
   endtask

   task automatic t_irq();
      wr_reg(5'h0F, 8'h01);
      pulse(8'h02);
      check("R6 masked event", {7'd0, irq}, 8'h00);
      pulse(8'h01);
      check("R6 enabled event", {7'd0, irq}, 8'h01);
      wr_reg(5'h07, 8'h01);
      check("R7 status clear drops irq", {7'd0, irq}, 8'h00);
      pulse(8'h01);
      wr_reg(5'h0F, 8'h00);
      check("R7 mask clear drops irq", {7'd0, irq}, 8'h00);
      wr_reg(5'h0F, 8'h01);
      check("R6 mask reenable", {7'd0, irq}, 8'h01);
      wr_reg(5'h0F, 8'h00);
      wr_reg(5'h07, 8'hFF);
   endtask

   task automatic t_rstport();
      logic [7:0] v;
      rd_reg(5'h1F, v); check("R8 port reads zero", v, 8'h00);
      rd_reg(5'h07, v); check("R8 bit7 set", v, 8'h80);
      wr_reg(5'h0F, 8'h80);
      check("R6 reset cause irq", {7'd0, irq}, 8'h01);
      wr_reg(5'h0F, 8'h00);
      wr_reg(5'h07, 8'hFF);
   endtask

   task automatic t_page1();
      logic [7:0] v;
      pulse(8'h04);
      wr_reg(5'h00, 8'h40);
      wr_reg(5'h07, 8'h5A);
      rd_reg(5'h07, v); check("R9 curpg rw", v, 8'h5A);
      rd_reg(5'h1F, v);
      wr_reg(5'h0F, 8'hFF);
      wr_reg(5'h00, 8'h00);
      rd_reg(5'h07, v); check("R9 status kept", v, 8'h04);
      check("R10 mask kept p1", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_page23();
      logic [7:0] v;
      wr_reg(5'h00, 8'h80);
      rd_reg(5'h07, v); check("R10 p2 reads zero", v, 8'h00);
      wr_reg(5'h07, 8'hFF);
      wr_reg(5'h0F, 8'hFF);
      rd_reg(5'h1F, v);
      wr_reg(5'h00, 8'hC0);
      rd_reg(5'h07, v); check("R10 p3 reads zero", v, 8'h00);
      wr_reg(5'h00, 8'h00);
      rd_reg(5'h07, v); check("R10 status kept", v, 8'h04);
      check("R10 mask kept p2", {7'd0, irq}, 8'h00);
      wr_reg(5'h00, 8'h40);
      rd_reg(5'h07, v); check("R10 curpg kept", v, 8'h5A);
      wr_reg(5'h00, 8'h00);
   endtask

   task automatic t_cmd();
      logic [7:0] v;
      wr_reg(5'h00, 8'h04);
      wr_reg(5'h00, 8'h00);
      rd_reg(5'h00, v); check("R2 bit2 sticks", v, 8'h04);
      wr_reg(5'h00, 8'h22);
      rd_reg(5'h00, v); check("R2 merge", v, 8'h26);
      wr_reg(5'h00, 8'h40);
      rd_reg(5'h00, v); check("R2 page1 cmd", v, 8'h44);
      rd_reg(5'h07, v); check("R2 page select", v, 8'h5A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_events();
      t_w1c();
      t_setwins();
      t_irq();
      t_rstport();
      t_page1();
      t_page23();
      t_cmd();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule